// File: doc/BRIEF.md
# Sixteen-Bit Three-Register Processor Core

A compact 16-bit load/store processor with eight general registers, a program counter, an instruction register and a run flag that a start input sets. While it runs, it alternates between a fetch step and an execute step. Fetch reads a 16-bit instruction word from an internal byte-organised memory at the current PC and advances the PC by two. Execute then performs exactly one operation: register or immediate arithmetic, bitwise logic, shifts, moves, a memory load or store, an I/O port read or write, a register-relative jump, a PC-relative conditional branch, a no-op, or a halt.

The memory and the I/O port array are inside the block. A test environment fills them through preload ports while the core is idle, starts the core with a pulse on `start`, and observes its architectural state through debug read ports. A one-cycle `step_done` pulse marks each completed instruction, and the results of that instruction are visible during the pulse.

Top module: `proc16_core`

## Requirements
- R1: A synchronous reset clears the PC to 0, clears the run flag and clears all eight registers to 0.
- R2: While the core is idle, start=1 sets the run flag at the next clock edge. With start=0 the run flag and the PC stay unchanged.
- R3: While the core is running, fetch loads the instruction word from the old PC and sets PC to PC+2 at the same edge. The next edge executes that word, so instructions complete every two cycles. Instruction fields are opcode=IR[15:11], ra=IR[10:8], rb=IR[7:5], rc=IR[4:2], c1=IR[4:0] and c2=IR[7:0].
- R4: Opcode 0 writes rb+rc to ra, opcode 1 writes rb+sext(c1), opcode 2 writes rb−rc and opcode 3 writes rb−sext(c1), all modulo 2^16.
- R5: Opcode 8 writes rb AND rc to ra, opcode 10 writes rb OR rc, opcode 14 writes NOT rc, opcode 6 writes rb and opcode 7 writes sext(c2).
- R6: Opcode 12 writes rb shifted right logically by N, opcode 13 writes rb shifted left logically by N, and opcode 15 writes rb shifted right with copies of bit 15. N is c1[3:0], so c1[4] has no effect on the amount.
- R7: Opcode 29 loads ra from the memory word at rb+sext(c1), and opcode 28 stores ra there. A word is little-endian: the low byte is at the address and the high byte is at address+1.
- R8: Opcode 24 reads I/O port c2 into ra, and opcode 25 writes ra to I/O port c2. The port index is the low bits of c2.
- R9: Opcode 20 sets PC to ra+sext(c2).
- R10: Opcode 16 sets PC to (PC already advanced by 2)+sext(c2) when its test holds. With rb field 000 the test is R0==0. For any other rb it is R[rb]!=0. When the test fails, the PC is not changed.
- R11: Opcode 21 and every unassigned opcode, including 4, 5 and 9, change no register.
- R12: Opcode 31 clears the run flag. After that no further instruction completes and the PC stays where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Sets the run flag while the core is idle |
| pre_mem_we | input | 1 | Preload byte write enable for memory |
| pre_mem_addr | input | 16 | Preload byte address |
| pre_mem_byte | input | 8 | Preload byte value |
| pre_io_we | input | 1 | Preload write enable for an I/O port |
| pre_io_idx | input | IOW (4) | Preload I/O port index |
| pre_io_word | input | 16 | Preload I/O port value |
| dbg_reg_sel | input | 3 | Register selected for observation |
| dbg_reg_val | output | 16 | Value of the selected register |
| dbg_pc | output | 16 | Current program counter |
| dbg_run | output | 1 | Run flag |
| dbg_mem_addr | input | 16 | Address of the memory word to observe |
| dbg_mem_word | output | 16 | Little-endian memory word at dbg_mem_addr |
| dbg_io_idx | input | IOW (4) | I/O port selected for observation |
| dbg_io_val | output | 16 | Value of the selected I/O port |
| step_done | output | 1 | One-cycle pulse after each executed instruction |

## Verification
After the edge that samples `start`, the run flag is visible in the next cycle. The fetch edge follows, and it shows PC+2 one cycle later. The execute edge comes after that, and its register, memory and PC results are visible while `step_done` is high in the next cycle. A monitor waits for each `step_done` pulse and samples at the falling edge. It pops the next expected entry from a queue that a reference model filled while the program was written. It then compares the PC and the destination register, and it also checks that consecutive pulses are exactly two cycles apart. Store and I/O-write results, and the frozen state after halt, are read through the debug ports once the run flag has dropped.

// File: rtl/proc16_pkg.sv
package proc16_pkg;

  localparam int XLEN = 16;

  // opcode values (field IR[15:11])
  localparam logic [4:0] OP_ADD  = 5'd0;
  localparam logic [4:0] OP_ADDI = 5'd1;
  localparam logic [4:0] OP_SUB  = 5'd2;
  localparam logic [4:0] OP_SUBI = 5'd3;
  localparam logic [4:0] OP_MOV  = 5'd6;
  localparam logic [4:0] OP_LDI  = 5'd7;
  localparam logic [4:0] OP_AND  = 5'd8;
  localparam logic [4:0] OP_OR   = 5'd10;
  localparam logic [4:0] OP_SRL  = 5'd12;
  localparam logic [4:0] OP_SLL  = 5'd13;
  localparam logic [4:0] OP_NOT  = 5'd14;
  localparam logic [4:0] OP_SRA  = 5'd15;
  localparam logic [4:0] OP_BR   = 5'd16;
  localparam logic [4:0] OP_JMP  = 5'd20;
  localparam logic [4:0] OP_NOP  = 5'd21;
  localparam logic [4:0] OP_IN   = 5'd24;
  localparam logic [4:0] OP_OUT  = 5'd25;
  localparam logic [4:0] OP_ST   = 5'd28;
  localparam logic [4:0] OP_LD   = 5'd29;
  localparam logic [4:0] OP_HLT  = 5'd31;

  typedef enum logic {PH_FETCH, PH_EXEC} phase_t;

  typedef enum logic [1:0] {SH_LR, SH_LL, SH_AR} shift_t;

  function automatic logic [XLEN-1:0] sext5(input logic [4:0] c);
    return {{(XLEN-5){c[4]}}, c};
  endfunction

  function automatic logic [XLEN-1:0] sext8(input logic [7:0] c);
    return {{(XLEN-8){c[7]}}, c};
  endfunction

  function automatic logic [XLEN-1:0] shift_calc(input shift_t kind,
                                                 input logic [XLEN-1:0] v,
                                                 input logic [3:0] n);
    case (kind)
      SH_LR:   return v >> n;
      SH_LL:   return v << n;
      default: return $unsigned($signed(v) >>> n);
    endcase
  endfunction

endpackage

// File: rtl/proc16_regfile.sv
module proc16_regfile #(
  parameter int NREG = 8,
  parameter int W    = 16,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] a_sel,
  input  logic [AW-1:0] b_sel,
  input  logic [AW-1:0] c_sel,
  input  logic [AW-1:0] d_sel,
  output logic [W-1:0]  a_val,
  output logic [W-1:0]  b_val,
  output logic [W-1:0]  c_val,
  output logic [W-1:0]  d_val
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign a_val = regs[a_sel];
  assign b_val = regs[b_sel];
  assign c_val = regs[c_sel];
  assign d_val = regs[d_sel];
endmodule

// File: rtl/proc16_mem.sv
module proc16_mem #(
  parameter int BYTES = 256,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(BYTES)
) (
  input  logic        clk,
  input  logic        pre_we,
  input  logic [15:0] pre_addr,
  input  logic [7:0]  pre_byte,
  input  logic        st_we,
  input  logic [15:0] st_addr,
  input  logic [15:0] st_word,
  input  logic [15:0] rd_addr [NRD],
  output logic [15:0] rd_word [NRD]
);
  logic [7:0]    bytes [BYTES];
  logic [AW-1:0] st_lo, st_hi;
  logic          unused_addr_hi;

  assign st_lo = st_addr[AW-1:0];
  assign st_hi = st_lo + 1'b1;
  assign unused_addr_hi = ^{pre_addr[15:AW], st_addr[15:AW]};

  // preload has priority; the core stores a word as two bytes, low first
  always_ff @(posedge clk) begin
    if (pre_we) begin
      bytes[pre_addr[AW-1:0]] <= pre_byte;
    end else if (st_we) begin
      bytes[st_lo] <= st_word[7:0];
      bytes[st_hi] <= st_word[15:8];
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [AW-1:0] lo, hi;
    logic          unused_rd_hi;
    assign lo = rd_addr[g][AW-1:0];
    assign hi = lo + 1'b1;
    assign unused_rd_hi = ^rd_addr[g][15:AW];
    assign rd_word[g] = {bytes[hi], bytes[lo]};
  end
endmodule

// File: rtl/proc16_exec.sv
module proc16_exec
  import proc16_pkg::*;
(
  input  logic [4:0]      op,
  input  logic [2:0]      rb_f,
  input  logic [4:0]      c1,
  input  logic [7:0]      c2,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] va,
  input  logic [XLEN-1:0] vb,
  input  logic [XLEN-1:0] vc,
  input  logic [XLEN-1:0] mem_word,
  input  logic [XLEN-1:0] io_word,
  output logic            reg_we,
  output logic [XLEN-1:0] reg_wdata,
  output logic            pc_we,
  output logic [XLEN-1:0] pc_new,
  output logic [XLEN-1:0] ls_addr,
  output logic            st_we,
  output logic            io_we,
  output logic            halt,
  output logic            br_taken
);
  always_comb begin
    reg_we    = 1'b0;
    reg_wdata = '0;
    pc_we     = 1'b0;
    pc_new    = pc;
    st_we     = 1'b0;
    io_we     = 1'b0;
    halt      = 1'b0;
    ls_addr   = vb + sext5(c1);
    br_taken  = (rb_f == 3'd0) ? (vb == '0) : (vb != '0);
    case (op)
      OP_ADD:  begin reg_we = 1'b1; reg_wdata = vb + vc;             end
      OP_ADDI: begin reg_we = 1'b1; reg_wdata = vb + sext5(c1);      end
      OP_SUB:  begin reg_we = 1'b1; reg_wdata = vb - vc;             end
      OP_SUBI: begin reg_we = 1'b1; reg_wdata = vb - sext5(c1);      end
      OP_MOV:  begin reg_we = 1'b1; reg_wdata = vb;                  end
      OP_LDI:  begin reg_we = 1'b1; reg_wdata = sext8(c2);           end
      OP_AND:  begin reg_we = 1'b1; reg_wdata = vb & vc;             end
      OP_OR:   begin reg_we = 1'b1; reg_wdata = vb | vc;             end
      OP_NOT:  begin reg_we = 1'b1; reg_wdata = ~vc;                 end
      OP_SRL:  begin reg_we = 1'b1; reg_wdata = shift_calc(SH_LR, vb, c1[3:0]); end
      OP_SLL:  begin reg_we = 1'b1; reg_wdata = shift_calc(SH_LL, vb, c1[3:0]); end
      OP_SRA:  begin reg_we = 1'b1; reg_wdata = shift_calc(SH_AR, vb, c1[3:0]); end
      OP_LD:   begin reg_we = 1'b1; reg_wdata = mem_word;            end
      OP_ST:   st_we = 1'b1;
      OP_IN:   begin reg_we = 1'b1; reg_wdata = io_word;             end
      OP_OUT:  io_we = 1'b1;
      OP_JMP:  begin pc_we = 1'b1; pc_new = va + sext8(c2);          end
      OP_BR:   begin pc_we = br_taken; pc_new = pc + sext8(c2);      end
      OP_HLT:  halt = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/proc16_core.sv
module proc16_core
  import proc16_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int IO_PORTS  = 16,
  localparam int IOW      = $clog2(IO_PORTS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            pre_mem_we,
  input  logic [15:0]     pre_mem_addr,
  input  logic [7:0]      pre_mem_byte,
  input  logic            pre_io_we,
  input  logic [IOW-1:0]  pre_io_idx,
  input  logic [15:0]     pre_io_word,
  input  logic [2:0]      dbg_reg_sel,
  output logic [15:0]     dbg_reg_val,
  output logic [15:0]     dbg_pc,
  output logic            dbg_run,
  input  logic [15:0]     dbg_mem_addr,
  output logic [15:0]     dbg_mem_word,
  input  logic [IOW-1:0]  dbg_io_idx,
  output logic [15:0]     dbg_io_val,
  output logic            step_done
);
  logic [XLEN-1:0] pc, ir;
  logic            run;
  phase_t          phase;
  logic [XLEN-1:0] io_q [IO_PORTS];

  // instruction fields
  logic [4:0] f_op, f_c1;
  logic [2:0] f_ra, f_rb, f_rc;
  logic [7:0] f_c2;
  assign f_op = ir[15:11];
  assign f_ra = ir[10:8];
  assign f_rb = ir[7:5];
  assign f_rc = ir[4:2];
  assign f_c1 = ir[4:0];
  assign f_c2 = ir[7:0];

  // named internal events
  logic fetch_fire, exec_fire;
  assign fetch_fire = run && (phase == PH_FETCH);
  assign exec_fire  = run && (phase == PH_EXEC);

  logic [XLEN-1:0] va, vb, vc;
  logic [XLEN-1:0] rd_addr [3];
  logic [XLEN-1:0] rd_word [3];
  logic            reg_we, pc_we, st_we, io_we, halt, br_taken;
  logic [XLEN-1:0] reg_wdata, pc_new, ls_addr;
  logic [IOW-1:0]  io_sel;
  logic            unused_c2_hi;

  assign io_sel       = f_c2[IOW-1:0];
  assign unused_c2_hi = ^f_c2[7:IOW];

  proc16_regfile #(.NREG(8), .W(XLEN)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (exec_fire && reg_we),
    .waddr (f_ra),
    .wdata (reg_wdata),
    .a_sel (f_ra),
    .b_sel (f_rb),
    .c_sel (f_rc),
    .d_sel (dbg_reg_sel),
    .a_val (va),
    .b_val (vb),
    .c_val (vc),
    .d_val (dbg_reg_val)
  );

  assign rd_addr[0] = pc;           // fetch
  assign rd_addr[1] = ls_addr;      // data load
  assign rd_addr[2] = dbg_mem_addr; // observation

  proc16_mem #(.BYTES(MEM_BYTES), .NRD(3)) u_mem (
    .clk      (clk),
    .pre_we   (pre_mem_we),
    .pre_addr (pre_mem_addr),
    .pre_byte (pre_mem_byte),
    .st_we    (exec_fire && st_we),
    .st_addr  (ls_addr),
    .st_word  (va),
    .rd_addr  (rd_addr),
    .rd_word  (rd_word)
  );

  proc16_exec u_exec (
    .op        (f_op),
    .rb_f      (f_rb),
    .c1        (f_c1),
    .c2        (f_c2),
    .pc        (pc),
    .va        (va),
    .vb        (vb),
    .vc        (vc),
    .mem_word  (rd_word[1]),
    .io_word   (io_q[io_sel]),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .pc_we     (pc_we),
    .pc_new    (pc_new),
    .ls_addr   (ls_addr),
    .st_we     (st_we),
    .io_we     (io_we),
    .halt      (halt),
    .br_taken  (br_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= '0;
      ir        <= '0;
      run       <= 1'b0;
      phase     <= PH_FETCH;
      step_done <= 1'b0;
    end else begin
      step_done <= 1'b0;
      if (!run) begin
        phase <= PH_FETCH;
        if (start) run <= 1'b1;
      end else if (phase == PH_FETCH) begin
        ir    <= rd_word[0];
        pc    <= pc + 16'd2;
        phase <= PH_EXEC;
      end else begin
        phase     <= PH_FETCH;
        step_done <= 1'b1;
        if (pc_we) pc <= pc_new;
        if (halt)  run <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pre_io_we)             io_q[pre_io_idx] <= pre_io_word;
    else if (exec_fire && io_we) io_q[io_sel]   <= va;
  end

  assign dbg_pc       = pc;
  assign dbg_run      = run;
  assign dbg_mem_word = rd_word[2];
  assign dbg_io_val   = io_q[dbg_io_idx];

  // idle without start: nothing moves
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!run && !start) |=> (!run && $stable(pc)));

  // fetch advances PC by two and hands over to execute
  assert_fetch_step_R3: assert property (@(posedge clk) disable iff (rst)
    fetch_fire |=> (pc == $past(pc) + 16'd2 && phase == PH_EXEC));

  // a failed branch test leaves PC alone
  assert_branch_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (exec_fire && f_op == OP_BR && !br_taken) |=> (pc == $past(pc)));

  // halt drops the run flag
  assert_halt_stop_R12: assert property (@(posedge clk) disable iff (rst)
    (exec_fire && halt) |=> !run);

  // no instruction completes while stopped
  assert_no_step_idle_R12: assert property (@(posedge clk) disable iff (rst)
    ($past(!run) && !run) |-> !step_done);
endmodule

// File: tb/proc16_core_bench.sv
module proc16_core_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        rst, start, pre_mem_we, pre_io_we;
  logic [15:0] pre_mem_addr, pre_io_word, dbg_mem_addr;
  logic [7:0]  pre_mem_byte;
  logic [3:0]  pre_io_idx, dbg_io_idx;
  logic [2:0]  dbg_reg_sel;
  logic [15:0] dbg_reg_val, dbg_pc, dbg_mem_word, dbg_io_val;
  logic        dbg_run, step_done;

  proc16_core u_proc16_core (
    .clk(clk), .rst(rst), .start(start),
    .pre_mem_we(pre_mem_we), .pre_mem_addr(pre_mem_addr), .pre_mem_byte(pre_mem_byte),
    .pre_io_we(pre_io_we), .pre_io_idx(pre_io_idx), .pre_io_word(pre_io_word),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_val(dbg_reg_val), .dbg_pc(dbg_pc),
    .dbg_run(dbg_run), .dbg_mem_addr(dbg_mem_addr), .dbg_mem_word(dbg_mem_word),
    .dbg_io_idx(dbg_io_idx), .dbg_io_val(dbg_io_val), .step_done(step_done)
  );

  int cyc = 0;
  always @(posedge clk) cyc++;

  int checks = 0;
  int errs   = 0;

  typedef struct {
    logic [15:0] pc;
    logic [2:0]  sel;
    logic [15:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];

  // reference model state
  logic [15:0] mr [8];
  logic [15:0] mpc;
  logic [7:0]  mm [256];
  logic [15:0] mio [16];

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] fr(input int op, input int ra, input int rb, input int rc);
    return {5'(op), 3'(ra), 3'(rb), 3'(rc), 2'b00};
  endfunction
  function automatic logic [15:0] fc1(input int op, input int ra, input int rb, input logic [4:0] c);
    return {5'(op), 3'(ra), 3'(rb), c};
  endfunction
  function automatic logic [15:0] fc2(input int op, input int ra, input logic [7:0] c);
    return {5'(op), 3'(ra), c};
  endfunction

  task automatic pre_byte(input logic [15:0] a, input logic [7:0] b);
    @(negedge clk);
    pre_mem_we = 1'b1; pre_mem_addr = a; pre_mem_byte = b;
    mm[a[7:0]] = b;
    @(negedge clk);
    pre_mem_we = 1'b0;
  endtask

  task automatic pre_io(input logic [3:0] i, input logic [15:0] w);
    @(negedge clk);
    pre_io_we = 1'b1; pre_io_idx = i; pre_io_word = w;
    mio[i] = w;
    @(negedge clk);
    pre_io_we = 1'b0;
  endtask

  // driver: writes the word at the model PC, runs the model, queues the expectation
  task automatic issue(input logic [15:0] w, input string tag);
    logic [4:0] op; logic [2:0] ra, rb, rc; logic [4:0] c1; logic [7:0] c2;
    int s1, s2; logic [15:0] nx, v, a; logic [7:0] lo, hi; logic cond;
    pre_byte(mpc, w[7:0]);
    pre_byte(mpc + 16'd1, w[15:8]);
    op = w[15:11]; ra = w[10:8]; rb = w[7:5]; rc = w[4:2]; c1 = w[4:0]; c2 = w[7:0];
    s1 = c1[4] ? int'(c1) - 32 : int'(c1);
    s2 = c2[7] ? int'(c2) - 256 : int'(c2);
    nx = mpc + 16'd2;
    v  = mr[rb];
    a  = 16'(int'(mr[rb]) + s1);
    lo = a[7:0]; hi = lo + 8'd1;
    case (int'(op))
      0:  mr[ra] = mr[rb] + mr[rc];
      1:  mr[ra] = 16'(int'(mr[rb]) + s1);
      2:  mr[ra] = 16'(int'(mr[rb]) - int'(mr[rc]));
      3:  mr[ra] = 16'(int'(mr[rb]) - s1);
      6:  mr[ra] = mr[rb];
      7:  mr[ra] = 16'(s2);
      8:  mr[ra] = mr[rb] & mr[rc];
      10: mr[ra] = mr[rb] | mr[rc];
      14: mr[ra] = mr[rc] ^ 16'hFFFF;
      12: begin repeat (int'(c1[3:0])) v = {1'b0, v[15:1]}; mr[ra] = v; end
      13: begin repeat (int'(c1[3:0])) v = {v[14:0], 1'b0}; mr[ra] = v; end
      15: begin repeat (int'(c1[3:0])) v = {v[15], v[15:1]}; mr[ra] = v; end
      29: mr[ra] = {mm[hi], mm[lo]};
      28: begin mm[lo] = mr[ra][7:0]; mm[hi] = mr[ra][15:8]; end
      24: mr[ra] = mio[c2[3:0]];
      25: mio[c2[3:0]] = mr[ra];
      20: nx = 16'(int'(mr[ra]) + s2);
      16: begin
        cond = (rb == 3'd0) ? (mr[0] == 16'd0) : (mr[rb] != 16'd0);
        if (cond) nx = 16'(int'(nx) + s2);
      end
      default: ;
    endcase
    q.push_back('{nx, ra, mr[ra], tag});
    mpc = nx;
  endtask

  // monitor: one expectation per completed instruction
  task automatic monitor();
    int last = -1;
    exp_t e;
    forever begin
      @(negedge clk);
      if (step_done) begin
        if (last >= 0) chk("R3", "cycles between completions", 16'(cyc - last), 16'd2);
        last = cyc;
        if (q.size() == 0) begin
          chk("R12", "unexpected completion", 16'd1, 16'd0);
        end else begin
          e = q.pop_front();
          dbg_reg_sel = e.sel;
          #1;
          chk(e.tag, "destination register", dbg_reg_val, e.val);
          chk(e.tag, "pc after step", dbg_pc, e.pc);
        end
      end
    end
  endtask

  task automatic watchdog();
    repeat (20000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=running expected=halted");
  endtask

  task automatic main_flow();
    rst = 1'b1; start = 1'b0; pre_mem_we = 1'b0; pre_io_we = 1'b0;
    pre_mem_addr = '0; pre_mem_byte = '0; pre_io_idx = '0; pre_io_word = '0;
    dbg_reg_sel = '0; dbg_mem_addr = '0; dbg_io_idx = '0;
    for (int i = 0; i < 8; i++) mr[i] = '0;
    for (int i = 0; i < 256; i++) mm[i] = '0;
    for (int i = 0; i < 16; i++) mio[i] = '0;
    mpc = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", "pc after reset", dbg_pc, 16'd0);
    chk("R1", "run after reset", 16'(dbg_run), 16'd0);
    for (int i = 0; i < 8; i++) begin
      dbg_reg_sel = 3'(i); #1;
      chk("R1", "register after reset", dbg_reg_val, 16'd0);
    end

    // data and I/O preload
    pre_byte(16'h00BE, 8'hCD); pre_byte(16'h00BF, 8'hAB);
    pre_byte(16'h00C0, 8'h34); pre_byte(16'h00C1, 8'h12);
    pre_io(4'd3, 16'hBEEF);

    // program
    issue(fc2(7, 1, 8'hFD), "R5");          // r1 = -3
    issue(fc2(7, 2, 8'h25), "R5");          // r2 = 0x25
    issue(fr(0, 3, 1, 2), "R4");            // add
    issue(fc1(1, 4, 2, 5'h10), "R4");       // addi -16
    issue(fr(2, 5, 2, 1), "R4");            // sub
    issue(fc1(3, 6, 2, 5'h0F), "R4");       // subi 15
    issue(fr(8, 3, 1, 2), "R5");            // and
    issue(fr(10, 4, 1, 2), "R5");           // or
    issue(fr(14, 7, 0, 2), "R5");           // not
    issue(fr(6, 0, 2, 0), "R5");            // mov
    issue(fc1(12, 4, 1, 5'h04), "R6");      // srl 4
    issue(fc1(13, 5, 2, 5'h13), "R6");      // sll, c1[4] set, amount 3
    issue(fc1(15, 6, 1, 5'h01), "R6");      // sra negative
    issue(fc1(15, 3, 5, 5'h02), "R6");      // sra positive
    issue(fc2(7, 6, 8'h60), "R5");
    issue(fr(0, 6, 6, 6), "R4");            // r6 = 0xC0
    issue(fc1(29, 1, 6, 5'h00), "R7");      // load 0x1234
    issue(fc1(28, 2, 6, 5'h04), "R7");      // store r2 at 0xC4
    issue(fc1(29, 3, 6, 5'h04), "R7");      // load it back
    issue(fc1(29, 5, 6, 5'h1E), "R7");      // negative offset, 0xBE
    issue(fc2(24, 4, 8'h03), "R8");         // in port 3
    issue(fc2(25, 1, 8'h05), "R8");         // out port 5
    issue(fr(4, 1, 2, 3), "R11");           // opcode 4 ignored
    issue(fr(5, 2, 1, 3), "R11");           // opcode 5 ignored
    issue(fr(9, 3, 1, 2), "R11");           // opcode 9 ignored
    issue(fc2(21, 0, 8'h00), "R11");        // nop
    issue(fc2(7, 7, 8'h50), "R5");
    issue(fc2(20, 7, 8'h10), "R9");         // jump to 0x60
    issue(fc2(16, 0, 8'h06), "R10");        // R0 != 0: not taken
    issue(fc2(7, 0, 8'h00), "R5");
    issue(fc2(16, 0, 8'h06), "R10");        // R0 == 0: taken
    issue(fc2(16, 0, 8'h22), "R10");        // rb=1 nonzero: taken
    issue(fc2(7, 2, 8'h00), "R5");
    issue(fc2(16, 0, 8'h44), "R10");        // rb=2 zero: not taken
    issue(fc2(31, 0, 8'h00), "R12");        // halt

    // R2 idle hold with start low
    repeat (4) @(negedge clk);
    chk("R2", "run while idle", 16'(dbg_run), 16'd0);
    chk("R2", "pc while idle", dbg_pc, 16'd0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2", "run after start", 16'(dbg_run), 16'd1);
    chk("R3", "pc before fetch", dbg_pc, 16'd0);
    @(negedge clk);
    chk("R3", "pc after fetch", dbg_pc, 16'd2);

    while (dbg_run) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R12", "no completion after halt", 16'(step_done), 16'd0);
    end
    chk("R12", "run after halt", 16'(dbg_run), 16'd0);
    chk("R12", "pc frozen after halt", dbg_pc, mpc);
    chk("R12", "pending expectations", 16'(q.size()), 16'd0);
    dbg_mem_addr = 16'h00C4; #1;
    chk("R7", "stored word little-endian", dbg_mem_word, {mm[8'hC5], mm[8'hC4]});
    dbg_mem_addr = 16'h00C5; #1;
    chk("R7", "stored high byte", {8'h00, dbg_mem_word[7:0]}, 16'h0000);
    dbg_io_idx = 4'd5; #1;
    chk("R8", "output port", dbg_io_val, mio[5]);
    dbg_io_idx = 4'd3; #1;
    chk("R8", "input port untouched", dbg_io_val, 16'hBEEF);
  endtask

  initial begin
    fork
      main_flow();
      watchdog();
      monitor();
    join_any
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule